// File: doc/BRIEF.md
# Two-Level Voltage Cycle Scheduler

This block plans how one task spends its cycle budget across a processor's discrete supply levels. A start pulse delivers the task's worst-case cycle count N and a deadline T. A level table supplies one clock frequency per level, given in cycles per time unit and sorted from slowest to fastest. The block computes a plan that uses at most two levels. These are the two table levels that sit directly above and below the ideal continuous frequency N/T. The plan is sized so that the task ends no later than T. Switching between levels is treated as taking no time.

Once the plan is ready, the block paces the task. Each executed cycle is reported on a tick input. The level select names the faster level for the first x cycles and the slower level for the rest. A done flag is raised when the budget is used up.

The state machine has six states:
- IDLE: after reset.
- PICK: chooses the levels.
- DIV: runs the sequential divide for x.
- RUN_HI: runs at the faster level.
- RUN_LO: runs at the slower level.
- FIN: the task is complete.

The transitions are:
- any state to PICK on start;
- PICK to FIN when N is zero;
- PICK to RUN_HI for a single-level plan;
- PICK to DIV for a split plan;
- DIV to RUN_HI when the divide completes;
- RUN_HI to RUN_LO on the tick that completes cycle x;
- RUN_HI to FIN, or RUN_LO to FIN, on the tick that completes cycle N.

Top module: `vsched_two_level`

## Requirements
- R1: After reset, level_o is 0 and run_o, done_o and infeas_o are all 0.
- R2: Table entry i of freq_tab_i is at bits [16*i+15:16*i], and entries ascend. The faster level is the lowest index k with f_k*T >= N. When f_k*T > N and k > 0, the slower level is k-1.
- R3: When f_k*T == N, or when k is 0, only level k is used and hi_cycles_o equals N.
- R4: For a split plan, hi_cycles_o = ceil(f_hi*(N - T*f_lo)/(f_hi - f_lo)). This is the smallest whole count x for which x/f_hi + (N-x)/f_lo does not exceed T.
- R5: While running, level_o first shows the faster level. It changes to the slower level at the clock edge that samples the x-th tick, and at no other time.
- R6: At the clock edge that samples the N-th tick, done_o goes to 1 and run_o goes to 0. done_o stays 1, and level_o stays unchanged, through any further ticks until the next start.
- R7: When f*T < N for every level, level NLVL-1 is used for all N cycles, infeas_o is 1 and hi_cycles_o equals N.
- R8: Ticks are counted only while run_o is 1. Ticks that arrive during planning are ignored.
- R9: A start with N = 0 leads to done_o = 1 without run_o ever rising.
- R10: A start pulse at any time, including mid-run, discards the current plan and plans the new task.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse; latches cycles_i and deadline_i |
| cycles_i | input | CW | Worst-case cycle count N |
| deadline_i | input | TW | Deadline T in time units |
| freq_tab_i | input | NLVL*FW | Frequencies of the levels in cycles per time unit, ascending |
| tick_i | input | 1 | One task cycle executed |
| level_o | output | LW | Selected level index |
| hi_cycles_o | output | CW | Cycles planned at the faster level |
| run_o | output | 1 | Task is being paced |
| done_o | output | 1 | Cycle budget consumed |
| infeas_o | output | 1 | Deadline cannot be met even at the top level |

## Verification
The plan logic is tried with tasks whose required frequency falls in each kind of place:
- strictly between two levels with an exact split, which checks the closed form;
- strictly between two levels with a fractional split, which shows whether the count is rounded up or down;
- exactly on a level, which must give no split;
- below the slowest level;
- above the fastest level, which separates the infeasible path from the split path.

The large 10^9-cycle, 25-second case confirms that the wide products do not overflow. Holding the tick input high through planning shows whether ticks are dropped before the run. A mid-run restart and a zero-length task probe the paths that leave the normal state sequence.

// File: rtl/vsched_pkg.sv
package vsched_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_PICK,
        S_DIV,
        S_RUN_HI,
        S_RUN_LO,
        S_FIN
    } vs_state_e;
endpackage

// File: rtl/vsched_level_pick.sv
module vsched_level_pick #(
    parameter int NLVL = 3,
    parameter int FW   = 16,
    parameter int CW   = 32,
    parameter int TW   = 32,
    parameter int LW   = 2
) (
    input  logic [NLVL-1:0][FW-1:0] freq_tab,
    input  logic [CW-1:0]           n_cyc,
    input  logic [TW-1:0]           t_dl,
    output logic [LW-1:0]           hi_idx,
    output logic                    single,
    output logic                    infeas
);
    localparam int PW = FW + TW;
    localparam int MW = (PW > CW) ? PW : CW;

    logic [NLVL-1:0] meet;
    logic [NLVL-1:0] exact;
    logic            found;

    // Per-level reachability: can level g finish N cycles within T?
    for (genvar g = 0; g < NLVL; g++) begin : g_lvl
        logic [PW-1:0] reach;
        assign reach    = PW'(freq_tab[g]) * PW'(t_dl);
        assign meet[g]  = MW'(reach) >= MW'(n_cyc);
        assign exact[g] = MW'(reach) == MW'(n_cyc);
    end

    // Lowest level that meets the deadline; top level if none does.
    always_comb begin
        hi_idx = LW'(NLVL - 1);
        found  = 1'b0;
        for (int i = NLVL - 1; i >= 0; i--) begin
            if (meet[i]) begin
                hi_idx = LW'(i);
                found  = 1'b1;
            end
        end
        infeas = !found;
        single = !found || (hi_idx == '0) || exact[hi_idx];
    end
endmodule

// File: rtl/vsched_seq_div.sv
module vsched_seq_div #(
    parameter int NW = 48,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [NW-1:0] num,
    input  logic [DW-1:0] den,
    output logic          done,
    output logic [NW-1:0] quo,
    output logic          rem_nz
);
    localparam int KW = $clog2(NW + 1);

    logic [NW-1:0] q_q;
    logic [DW:0]   r_q;
    logic [DW-1:0] d_q;
    logic [KW-1:0] k_q;
    logic          busy_q;
    logic [DW:0]   shifted;
    logic          ge;

    // One restoring step: shift in the next dividend bit, subtract if it fits.
    assign shifted = {r_q[DW-1:0], q_q[NW-1]};
    assign ge      = shifted >= {1'b0, d_q};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_q    <= '0;
            r_q    <= '0;
            d_q    <= '0;
            k_q    <= '0;
            busy_q <= 1'b0;
            done   <= 1'b0;
        end else if (start) begin
            q_q    <= num;
            r_q    <= '0;
            d_q    <= den;
            k_q    <= '0;
            busy_q <= 1'b1;
            done   <= 1'b0;
        end else if (busy_q) begin
            r_q <= ge ? (shifted - {1'b0, d_q}) : shifted;
            q_q <= {q_q[NW-2:0], ge};
            k_q <= k_q + 1'b1;
            if (k_q == KW'(NW - 1)) begin
                busy_q <= 1'b0;
                done   <= 1'b1;
            end
        end else begin
            done <= 1'b0;
        end
    end

    assign quo    = q_q;
    assign rem_nz = |r_q;
endmodule

// File: rtl/vsched_two_level.sv
module vsched_two_level
    import vsched_pkg::*;
#(
    parameter int NLVL = 3,
    parameter int FW   = 16,
    parameter int CW   = 32,
    parameter int TW   = 32,
    parameter int LW   = (NLVL > 1) ? $clog2(NLVL) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    input  logic [CW-1:0]           cycles_i,
    input  logic [TW-1:0]           deadline_i,
    input  logic [NLVL-1:0][FW-1:0] freq_tab_i,
    input  logic                    tick_i,
    output logic [LW-1:0]           level_o,
    output logic [CW-1:0]           hi_cycles_o,
    output logic                    run_o,
    output logic                    done_o,
    output logic                    infeas_o
);
    localparam int PW = FW + TW;
    localparam int MW = (PW > CW) ? PW : CW;
    localparam int NW = FW + CW;

    vs_state_e     state_q, state_d;
    logic [CW-1:0] n_q, x_q, cnt_q, cnt_inc;
    logic [TW-1:0] t_q;
    logic [LW-1:0] hi_q, lo_q;

    logic [LW-1:0] pick_hi;
    logic          pick_single, pick_infeas;
    logic [FW-1:0] f_hi, f_lo;
    logic [PW-1:0] t_flo;
    logic [MW-1:0] gap_w;
    logic [NW-1:0] div_num;
    logic          div_start, div_done, div_rem_nz;
    logic [NW-1:0] div_quo;

    vsched_level_pick #(
        .NLVL(NLVL), .FW(FW), .CW(CW), .TW(TW), .LW(LW)
    ) u_pick (
        .freq_tab (freq_tab_i),
        .n_cyc    (n_q),
        .t_dl     (t_q),
        .hi_idx   (pick_hi),
        .single   (pick_single),
        .infeas   (pick_infeas)
    );

    // Split numerator f_hi*(N - T*f_lo) and denominator f_hi - f_lo.
    assign f_hi    = freq_tab_i[pick_hi];
    assign f_lo    = freq_tab_i[pick_hi - 1'b1];
    assign t_flo   = PW'(t_q) * PW'(f_lo);
    assign gap_w   = MW'(n_q) - MW'(t_flo);
    assign div_num = NW'(f_hi) * NW'(gap_w[CW-1:0]);

    assign div_start = (state_q == S_PICK) && !start_i && (n_q != '0) && !pick_single;
    assign cnt_inc   = cnt_q + 1'b1;

    vsched_seq_div #(.NW(NW), .DW(FW)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (div_start),
        .num    (div_num),
        .den    (f_hi - f_lo),
        .done   (div_done),
        .quo    (div_quo),
        .rem_nz (div_rem_nz)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        if (start_i) begin
            state_d = S_PICK;
        end else begin
            unique case (state_q)
                S_IDLE: state_d = S_IDLE;
                S_PICK: begin
                    if (n_q == '0)       state_d = S_FIN;
                    else if (pick_single) state_d = S_RUN_HI;
                    else                  state_d = S_DIV;
                end
                S_DIV:    if (div_done) state_d = S_RUN_HI;
                S_RUN_HI: if (tick_i) begin
                    if (cnt_inc == n_q)      state_d = S_FIN;
                    else if (cnt_inc == x_q) state_d = S_RUN_LO;
                end
                S_RUN_LO: if (tick_i && cnt_inc == n_q) state_d = S_FIN;
                S_FIN:    state_d = S_FIN;
                default:  state_d = S_IDLE;
            endcase
        end
    end

    // Datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            n_q      <= '0;
            t_q      <= '0;
            x_q      <= '0;
            cnt_q    <= '0;
            hi_q     <= '0;
            lo_q     <= '0;
            level_o  <= '0;
            run_o    <= 1'b0;
            done_o   <= 1'b0;
            infeas_o <= 1'b0;
        end else if (start_i) begin
            n_q      <= cycles_i;
            t_q      <= deadline_i;
            cnt_q    <= '0;
            run_o    <= 1'b0;
            done_o   <= 1'b0;
            infeas_o <= 1'b0;
        end else begin
            unique case (state_q)
                S_IDLE: ;
                S_PICK: begin
                    hi_q <= pick_hi;
                    lo_q <= pick_hi - 1'b1;
                    if (n_q == '0) begin
                        x_q    <= '0;
                        done_o <= 1'b1;
                    end else if (pick_single) begin
                        x_q      <= n_q;
                        level_o  <= pick_hi;
                        run_o    <= 1'b1;
                        infeas_o <= pick_infeas;
                    end
                end
                S_DIV: if (div_done) begin
                    x_q     <= div_quo[CW-1:0] + CW'(div_rem_nz);
                    level_o <= hi_q;
                    run_o   <= 1'b1;
                end
                S_RUN_HI, S_RUN_LO: if (tick_i) begin
                    cnt_q <= cnt_inc;
                    if (cnt_inc == n_q) begin
                        run_o  <= 1'b0;
                        done_o <= 1'b1;
                    end else if (state_q == S_RUN_HI && cnt_inc == x_q) begin
                        level_o <= lo_q;
                    end
                end
                S_FIN: ;
                default: ;
            endcase
        end
    end

    assign hi_cycles_o = x_q;
endmodule

// File: rtl/vsched_checker.sv
module vsched_checker #(
    parameter int NLVL = 3,
    parameter int CW   = 32,
    parameter int LW   = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start_i,
    input logic          tick_i,
    input logic [LW-1:0] level_o,
    input logic [CW-1:0] hi_cycles_o,
    input logic [CW-1:0] n_q,
    input logic          run_o,
    input logic          done_o,
    input logic          infeas_o
);
    a_r2_level_in_table: assert property (@(posedge clk) disable iff (!rst_n)
        level_o < LW'(NLVL));

    a_r4_split_within_budget: assert property (@(posedge clk) disable iff (!rst_n)
        run_o |-> (hi_cycles_o <= n_q));

    a_r5_level_holds_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (run_o && !tick_i && !start_i) |=> $stable(level_o));

    a_r5_level_never_rises: assert property (@(posedge clk) disable iff (!rst_n)
        (run_o && !start_i) |=> (level_o <= $past(level_o)));

    a_r6_done_not_running: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && run_o));

    a_r6_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> done_o);

    a_r7_infeasible_top: assert property (@(posedge clk) disable iff (!rst_n)
        (infeas_o && run_o) |-> (level_o == LW'(NLVL - 1)));
endmodule

bind vsched_two_level vsched_checker #(.NLVL(NLVL), .CW(CW), .LW(LW)) u_vsched_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .tick_i      (tick_i),
    .level_o     (level_o),
    .hi_cycles_o (hi_cycles_o),
    .n_q         (n_q),
    .run_o       (run_o),
    .done_o      (done_o),
    .infeas_o    (infeas_o)
);

// File: tb/test_vsched_two_level.sv
`timescale 1ns/1ps
module test_vsched_two_level;
    localparam int NLVL = 3;
    localparam int FW   = 16;
    localparam int CW   = 32;
    localparam int TW   = 32;
    localparam int LW   = 2;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    start_i = 1'b0;
    logic [CW-1:0]           cycles_i = '0;
    logic [TW-1:0]           deadline_i = '0;
    logic [NLVL-1:0][FW-1:0] freq_tab_i;
    logic                    tick_i = 1'b0;
    logic [LW-1:0]           level_o;
    logic [CW-1:0]           hi_cycles_o;
    logic                    run_o, done_o, infeas_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    vsched_two_level #(.NLVL(NLVL), .FW(FW), .CW(CW), .TW(TW), .LW(LW)) i_vsched_two_level (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .cycles_i(cycles_i),
        .deadline_i(deadline_i), .freq_tab_i(freq_tab_i), .tick_i(tick_i),
        .level_o(level_o), .hi_cycles_o(hi_cycles_o), .run_o(run_o),
        .done_o(done_o), .infeas_o(infeas_o)
    );

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Split count from the requirement formula: ceil(fh*(N - T*fl)/(fh - fl))
    function automatic longint split_x(longint fh, longint fl, longint n, longint t);
        longint num = fh * (n - t * fl);
        longint den = fh - fl;
        return (num + den - 1) / den;
    endfunction

    task automatic launch(input longint n, input longint t);
        @(negedge clk);
        cycles_i   = CW'(n);
        deadline_i = TW'(t);
        start_i    = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int w = 0; w < 200; w++) begin
            if (run_o || done_o) break;
            @(negedge clk);
        end
    endtask

    task automatic pulse_ticks(input int k);
        for (int i = 0; i < k; i++) begin
            @(negedge clk) tick_i = 1'b1;
            @(negedge clk) tick_i = 1'b0;
        end
    endtask

    // Runs a plan to the end, checking level, switch point and completion.
    task automatic run_plan(input string req, input int n, input int x, input int lhi, input int llo);
        int bad = 0;
        for (int i = 0; i < x - 1; i++) begin
            pulse_ticks(1);
            if (level_o != LW'(lhi) || !run_o) bad++;
        end
        check({req, " R5 high level held before switch"}, bad, 0);
        pulse_ticks(1);
        if (x < n) begin
            check({req, " R5 level after x-th tick"}, level_o, llo);
            bad = 0;
            for (int i = 0; i < n - x - 1; i++) begin
                pulse_ticks(1);
                if (level_o != LW'(llo) || !run_o) bad++;
            end
            check({req, " R5 low level held"}, bad, 0);
            pulse_ticks(1);
        end
        check({req, " R6 done after N ticks"}, done_o, 1);
        check({req, " R6 run cleared"}, run_o, 0);
    endtask

    task automatic t_reset;
        check("R1 level", level_o, 0);
        check("R1 run", run_o, 0);
        check("R1 done", done_o, 0);
        check("R1 infeasible", infeas_o, 0);
    endtask

    task automatic t_split_exact;
        launch(1000, 22);
        check("R2 faster level", level_o, 2);
        check("R4 exact split", hi_cycles_o, split_x(50, 40, 1000, 22));
        check("R7 feasible flag", infeas_o, 0);
        run_plan("split exact", 1000, 600, 2, 1);
    endtask

    task automatic t_split_round;
        launch(1000, 30);
        check("R2 faster level", level_o, 1);
        check("R4 rounded-up split", hi_cycles_o, split_x(40, 25, 1000, 30));
        run_plan("split round", 1000, 667, 1, 0);
    endtask

    task automatic t_single_exact;
        launch(400, 10);
        check("R3 exact level", level_o, 1);
        check("R3 no split", hi_cycles_o, 400);
        run_plan("R3 exact", 400, 400, 1, 1);
    endtask

    task automatic t_single_lowest;
        launch(100, 10);
        check("R3 lowest level", level_o, 0);
        check("R3 lowest no split", hi_cycles_o, 100);
        run_plan("R3 lowest", 100, 100, 0, 0);
    endtask

    task automatic t_infeasible;
        launch(1000, 10);
        check("R7 top level", level_o, 2);
        check("R7 flag", infeas_o, 1);
        check("R7 all cycles high", hi_cycles_o, 1000);
        run_plan("R7 infeasible", 1000, 1000, 2, 2);
    endtask

    task automatic t_done_hold;
        logic [LW-1:0] lvl = level_o;
        pulse_ticks(3);
        check("R6 done held through ticks", done_o, 1);
        check("R6 level unchanged after done", level_o, lvl);
        check("R6 run stays low", run_o, 0);
    endtask

    task automatic t_tick_hold;
        int seen = 0;
        int guard = 0;
        @(negedge clk);
        tick_i     = 1'b1;
        cycles_i   = 100;
        deadline_i = 3;
        start_i    = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        while (!done_o && guard < 1000) begin
            if (run_o) seen++;
            guard++;
            @(negedge clk);
        end
        tick_i = 1'b0;
        check("R8 ticks counted only while running", seen, 100);
        check("R8 split for held tick", hi_cycles_o, split_x(40, 25, 100, 3));
    endtask

    task automatic t_zero;
        bit saw_run = 1'b0;
        @(negedge clk);
        cycles_i = 0;
        deadline_i = 5;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int i = 0; i < 5; i++) begin
            if (run_o) saw_run = 1'b1;
            @(negedge clk);
        end
        check("R9 zero task done", done_o, 1);
        check("R9 zero task never runs", saw_run, 0);
    endtask

    task automatic t_big_and_restart;
        launch(64'd1000000000, 64'd25000000);
        check("R3 large exact level", level_o, 1);
        check("R3 large no split", hi_cycles_o, 64'd1000000000);
        pulse_ticks(5);
        check("R10 running before restart", run_o, 1);
        launch(1000, 22);
        check("R10 new plan level", level_o, 2);
        check("R10 new plan split", hi_cycles_o, 600);
        run_plan("R10 restart", 1000, 600, 2, 1);
    endtask

    initial begin
        freq_tab_i[0] = 16'd25;
        freq_tab_i[1] = 16'd40;
        freq_tab_i[2] = 16'd50;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_split_exact();
        t_done_hold();
        t_split_round();
        t_single_exact();
        t_single_lowest();
        t_infeasible();
        t_tick_hold();
        t_zero();
        t_big_and_restart();
        if (!finished) begin
            finished = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(20ns * 190000);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule